// File: doc/BRIEF.md
# Segment-Truncating Single-Port RAM

This block is a synchronous single-port memory that presents an N-bit data word at its ports but keeps only the upper M bits of every word in its storage array. The upper segment of the write data is kept. The lower N-M bits are dropped. This saves storage in pipelines that can tolerate errors, such as image line buffers, where small errors in low bits are acceptable.

On a read, the stored segment is placed back at the top of an N-bit word. The bit directly under the segment is set to one and every bit below that is zero. The rebuilt value sits in the middle of the range of words that share the segment, so the worst-case error is half what zero-filling would give. With M equal to N, the block is a plain RAM.

A raster input switches write addressing from the external address to an internal pointer. The pointer steps once per write, so a stream of samples lands in consecutive locations. Reads always use the external address. The read result is registered and appears one clock edge after the request.

Top module: `seg_ram`

## Requirements
- R1: While `en_i` is low, no location is written and `rdata_o` keeps its value.
- R2: On an edge with `en_i` high and `wr_i` high, bits [N-1:N-M] of `wdata_i` are stored. The target is `addr_i` when `raster_i` is low and the raster pointer when it is high.
- R3: On an edge with `en_i` high and `wr_i` low, with M < N, `rdata_o` becomes {stored segment, 1, zeros}. The segment occupies bits [N-1:N-M], bit N-M-1 is 1, and bits below it are 0.
- R4: With M = N, a read returns exactly the word that was last written to that address.
- R5: The raster pointer is 0 after reset and advances by one on each enabled write taken with `raster_i` high. It wraps from DEPTH-1 to 0 and is unchanged by every other cycle.
- R6: While `rst_n` is low, `rdata_o` is all zeros.
- R7: A write cycle leaves `rdata_o` unchanged; `wr_i` selects exactly one operation per enabled cycle.
- R8: Read data is valid after the first rising edge following the request, and reads always use `addr_i`, even with `raster_i` high.
- R9: The block works at a depth of 1024 words for N=16 with M of 10, 12, 14 or 16, and for N=8 with M=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Access enable |
| wr_i | input | 1 | 1 = write, 0 = read (when enabled) |
| raster_i | input | 1 | 1 = writes go to the internal sequential pointer |
| addr_i | input | $clog2(DEPTH) | Read address; write address when raster is off |
| wdata_i | input | N | Write data, full logical width |
| rdata_o | output | N | Registered, re-padded read data |

## Verification
The bench targets the padding boundary with all-ones and all-zeros words. A design that pads with zeros or places the marker bit one position off returns values that differ in the low bits. It drives the pointer through a full wrap of 1024 writes and then reads location 0. A pointer that saturates, or wraps one step early or late, leaves the wrong data there. Idle cycles with changing write data and raster writes mixed with reads at other addresses expose a design that writes while disabled, reads through the pointer, or updates the output on a write. A full-width instance and an 8-bit instance check that the padding disappears when M equals N and that it scales with the parameters.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;

    // Kind of access taken on one clock edge.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_e;

    // Address width for a given depth (at least one bit).
    function automatic int addr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/seg_ram_trunc.sv
// Keeps the most significant M bits of an N-bit word.
module seg_ram_trunc #(
    parameter int N = 16,
    parameter int M = 12
) (
    input  logic [N-1:0] word_i,
    output logic [M-1:0] seg_o
);
    assign seg_o = word_i[N-1 -: M];
endmodule

// File: rtl/seg_ram_pad.sv
// Widens an M-bit segment back to N bits: marker one under the segment,
// zeros below it. No padding when M equals N.
module seg_ram_pad #(
    parameter int N = 16,
    parameter int M = 12
) (
    input  logic [M-1:0] seg_i,
    output logic [N-1:0] word_o
);
    localparam int GAP = N - M;

    generate
        if (GAP == 0) begin : g_full
            assign word_o = seg_i;
        end else if (GAP == 1) begin : g_one
            assign word_o = {seg_i, 1'b1};
        end else begin : g_wide
            assign word_o = {seg_i, 1'b1, {(GAP-1){1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/seg_ram_store.sv
// Behavioural segment array: one synchronous write port, combinational read.
module seg_ram_store #(
    parameter int W     = 12,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wseg_i,
    output logic [W-1:0]  rseg_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wseg_i;
        end
    end

    assign rseg_o = mem_q[addr_i];
endmodule

// File: rtl/seg_ram.sv
module seg_ram
    import seg_ram_pkg::*;
#(
    parameter int N     = 16,
    parameter int M     = 12,
    parameter int DEPTH = 1024,
    localparam int AW   = addr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          wr_i,
    input  logic          raster_i,
    input  logic [AW-1:0] addr_i,
    input  logic [N-1:0]  wdata_i,
    output logic [N-1:0]  rdata_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [N-1:0]  rdata;
    } state_t;

    state_t        st_d, st_q;
    acc_e          acc;
    logic [AW-1:0] acc_addr;
    logic [M-1:0]  wseg, rseg;
    logic [N-1:0]  rword;
    logic [AW-1:0] raster_ptr;

    always_comb begin
        if (!en_i)     acc = ACC_NONE;
        else if (wr_i) acc = ACC_WRITE;
        else           acc = ACC_READ;
    end

    assign acc_addr   = (acc == ACC_WRITE && raster_i) ? st_q.ptr : addr_i;
    assign raster_ptr = st_q.ptr;

    seg_ram_trunc #(.N(N), .M(M)) u_trunc (
        .word_i (wdata_i),
        .seg_o  (wseg)
    );

    seg_ram_store #(.W(M), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk    (clk),
        .we_i   (acc == ACC_WRITE),
        .addr_i (acc_addr),
        .wseg_i (wseg),
        .rseg_o (rseg)
    );

    seg_ram_pad #(.N(N), .M(M)) u_pad (
        .seg_i  (rseg),
        .word_o (rword)
    );

    always_comb begin
        st_d = st_q;
        unique case (acc)
            ACC_WRITE: begin
                if (raster_i) begin
                    st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
                end
            end
            ACC_READ: st_d.rdata = rword;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/seg_ram_chk.sv
module seg_ram_chk #(
    parameter int N     = 16,
    parameter int M     = 12,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_i,
    input logic          wr_i,
    input logic          raster_i,
    input logic [N-1:0]  rdata_o,
    input logic [AW-1:0] ptr_i
);
    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(rdata_o)); // R1

    AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_i) |=> $stable(rdata_o)); // R7

    AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_i && raster_i && ptr_i != AW'(DEPTH-1)) |=> ptr_i == $past(ptr_i) + 1'b1); // R5

    AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_i && raster_i && ptr_i == AW'(DEPTH-1)) |=> ptr_i == '0); // R5

    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && wr_i && raster_i) |=> $stable(ptr_i)); // R5

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (rdata_o == '0); // R6
        end
    end

    generate
        if (M < N) begin : g_pad
            AST_READ_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && !wr_i) |=> rdata_o[N-M-1] == 1'b1); // R3
        end
    endgenerate
endmodule

bind seg_ram seg_ram_chk #(.N(N), .M(M), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .wr_i     (wr_i),
    .raster_i (raster_i),
    .rdata_o  (rdata_o),
    .ptr_i    (raster_ptr)
);

// File: tb/seg_ram_tb.sv
module seg_ram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int AW         = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, wr = 1'b0, raster = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rd_main, rd_full;
    logic [7:0]    rd_nar;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [15:0] mdl [DEPTH];
    int          ptr = 0;
    logic [15:0] exp_main = '0, exp_full = '0;
    logic [7:0]  exp_nar = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_ram #(.N(16), .M(12), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .wr_i(wr), .raster_i(raster),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_main));

    seg_ram #(.N(16), .M(16), .DEPTH(DEPTH)) u_dut_full (
        .clk(clk), .rst_n(rst_n), .en_i(en), .wr_i(wr), .raster_i(raster),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_full));

    seg_ram #(.N(8), .M(4), .DEPTH(DEPTH)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .en_i(en), .wr_i(wr), .raster_i(raster),
        .addr_i(addr), .wdata_i(wdata[7:0]), .rdata_o(rd_nar));

    // Expected read value: top m of n bits kept, bit n-m-1 set, rest clear.
    function automatic logic [15:0] pad_model(input logic [15:0] w, input int n, input int m);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) begin
            if (i >= n - m)          r[i] = w[i];
            else if (i == n - m - 1) r[i] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R9 n16m12"}, rd_main, exp_main);
        check({tag, " R4 full"}, rd_full, exp_full);
        check({tag, " R9 n8m4"}, {8'h0, rd_nar}, {8'h0, exp_nar});
    endtask

    // One access: drive at negedge, edge, update model, sample at next negedge.
    task automatic op(input logic e, input logic w, input logic r,
                      input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        en = e; wr = w; raster = r; addr = a; wdata = d;
        @(posedge clk);
        if (e) begin
            if (w) begin
                if (r) begin
                    mdl[ptr] = d;
                    ptr = (ptr + 1) % DEPTH;
                end else begin
                    mdl[a] = d;
                end
            end else begin
                exp_main = pad_model(mdl[a], 16, 12);
                exp_full = mdl[a];
                exp_nar  = pad_model({8'h0, mdl[a][7:0]}, 8, 4)[7:0];
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;

        // R6: reset clears the output
        repeat (3) @(negedge clk);
        check_all("R6 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R5, R7: raster fill of every location; output must not move
        for (int i = 0; i < DEPTH; i++) begin
            op(1'b1, 1'b1, 1'b1, AW'($urandom), 16'($urandom), "R5 R7 raster fill");
        end
        // R5: wrap - next raster write lands at 0
        op(1'b1, 1'b1, 1'b1, 10'd700, 16'hBEEF, "R5 wrap write");
        op(1'b1, 1'b0, 1'b0, 10'd0, 16'h0, "R5 R8 read wrapped loc");
        op(1'b1, 1'b0, 1'b1, 10'd1, 16'h0, "R8 raster read uses addr");

        // R3: padding boundaries
        op(1'b1, 1'b1, 1'b0, 10'd1023, 16'hFFFF, "R2 write ones");
        op(1'b1, 1'b0, 1'b0, 10'd1023, 16'h0, "R3 read ones");
        op(1'b1, 1'b1, 1'b0, 10'd5, 16'h0000, "R2 write zeros");
        op(1'b1, 1'b0, 1'b0, 10'd5, 16'h0, "R3 read zeros");
        op(1'b1, 1'b1, 1'b0, 10'd6, 16'h0F0F, "R2 write low-only");
        op(1'b1, 1'b0, 1'b0, 10'd6, 16'h0, "R3 read low-only");

        // R1: disabled write attempt then read back
        op(1'b0, 1'b1, 1'b0, 10'd5, 16'h1234, "R1 idle write");
        op(1'b0, 1'b0, 1'b0, 10'd6, 16'h0, "R1 idle read");
        op(1'b1, 1'b0, 1'b0, 10'd5, 16'h0, "R1 idle no store");

        // Random mixed traffic
        for (int i = 0; i < 4000; i++) begin
            logic e, w, r;
            e = ($urandom % 5) != 0;
            w = $urandom % 2;
            r = ($urandom % 3) == 0;
            op(e, w, r, AW'($urandom), 16'($urandom), "R1 R2 R3 R7 R8 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule